// File: doc/BRIEF.md
# Floating-Point Mantissa Rounding Stage

This block is a purely combinational rounding step for a floating-point datapath. It receives an unrounded mantissa whose two lowest bits hold extra precision, a separate sticky bit, the sign of the value and a 2-bit rounding-mode select. It removes the two extra low bits and decides whether the remaining value must be bumped by one unit in the last place. The decision follows the four IEEE-754 rounding directions. Along with the rounded mantissa it reports three flags: an increment was applied, the result is inexact, and the fraction was rounded.

The output mantissa is one bit wider than the truncated value. An increment of an all-ones mantissa therefore shows up as a carry in the top bit, which is the value 2.0 in the integer position. Renormalising that carry, adjusting the exponent and packing the result into a storage format are left to the logic that follows.

Top module: `mant_round`

## Requirements
- R1: `mant_o` carries `mant_i[MANT_W-1:2]`, zero-extended by one bit at the top, whenever no increment is applied. No new sticky bit is formed from the discarded bits.
- R2: When `mant_i[1]` (guard), `mant_i[0]` (round) and `sticky_i` are all 0, the result is exact in every mode. `round_up_o`, `inexact_o` and `frac_rounded_o` are all 0.
- R3: `inexact_o` equals guard OR round OR sticky, in every mode.
- R4: With `mode_i` = 2'b00 (nearest, ties to even), an increment happens exactly when guard is 1 and at least one of round, sticky or the truncated LSB (`mant_i[2]`) is 1.
- R5: With `mode_i` = 2'b01 (toward zero), no increment ever happens.
- R6: With `mode_i` = 2'b10 (toward plus infinity), an increment happens exactly when the result is inexact and `sign_i` is 0.
- R7: With `mode_i` = 2'b11 (toward minus infinity), an increment happens exactly when the result is inexact and `sign_i` is 1.
- R8: On an increment, `mant_o` equals the zero-extended truncated value plus one, with the carry rippling through every bit. `round_up_o` and `frac_rounded_o` are both 1 on an increment and both 0 otherwise.
- R9: Incrementing an all-ones truncated value gives `mant_o` with only bit `MANT_W-2` set (the 2.0 case). It is passed on without renormalisation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mant_i | input | MANT_W | Unrounded mantissa; bit 1 is guard, bit 0 is round |
| sticky_i | input | 1 | OR of all bits below the round bit |
| sign_i | input | 1 | Sign of the value (1 = negative) |
| mode_i | input | 2 | Rounding direction: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| mant_o | output | MANT_W-1 | Rounded mantissa with the carry-out position on top |
| round_up_o | output | 1 | An increment was applied |
| inexact_o | output | 1 | Discarded bits were nonzero |
| frac_rounded_o | output | 1 | The fraction was rounded up |

## Verification
Every result is combinational, so each one is due in the same cycle its inputs are applied, with no register delay. The bench drives a new input set on the falling clock edge and samples all four outputs one nanosecond later, well before the next rising edge. Each sample is compared with values the bench computes from the mode rules above. The bound checker re-evaluates its properties whenever the ports settle.

// File: rtl/mant_round_pkg.sv
// Package: shared types for the mantissa rounding stage.
// Holds the rounding-direction encoding used by the decision logic.
package mant_round_pkg;

    // Rounding-direction encoding carried on the 2-bit mode port.
    typedef enum logic [1:0] {
        RND_NEAREST_EVEN = 2'b00,
        RND_TOWARD_ZERO  = 2'b01,
        RND_TOWARD_POS   = 2'b10,
        RND_TOWARD_NEG   = 2'b11
    } rnd_mode_e;

endpackage

// File: rtl/mant_round_decide.sv
// Module: mant_round_decide
// Decides whether the truncated mantissa must be incremented, and whether
// the result is inexact. Assumes the guard/round bits and the truncated
// LSB are already split out by the caller. Any mode code not listed in the
// package falls back to nearest-even.
module mant_round_decide
    import mant_round_pkg::*;
(
    input  logic       guard_i,
    input  logic       round_i,
    input  logic       sticky_i,
    input  logic       lsb_i,
    input  logic       sign_i,
    input  logic [1:0] mode_i,
    output logic       inexact_o,
    output logic       incr_o
);

    logic      lost_bits;
    rnd_mode_e mode;

    // Purpose: flag any nonzero discarded information.
    assign lost_bits = guard_i | round_i | sticky_i;
    assign inexact_o = lost_bits;
    assign mode      = rnd_mode_e'(mode_i);

    // Purpose: pick the increment decision for the selected direction.
    always_comb begin
        incr_o = 1'b0;
        case (mode)
            RND_TOWARD_ZERO: incr_o = 1'b0;
            RND_TOWARD_POS:  incr_o = lost_bits & ~sign_i;
            RND_TOWARD_NEG:  incr_o = lost_bits & sign_i;
            default:         incr_o = guard_i & (round_i | sticky_i | lsb_i);
        endcase
    end

endmodule

// File: rtl/mant_round_incr.sv
// Module: mant_round_incr
// Adds a single increment bit to a WIDTH-bit value, producing WIDTH+1 bits.
// The carry into each SEG_W-bit segment is the increment ANDed with the
// all-ones test of every lower bit, so segments do not ripple in series.
// The last segment takes whatever width remains.
module mant_round_incr #(
    parameter int WIDTH = 54,
    parameter int SEG_W = 8
) (
    input  logic [WIDTH-1:0] val_i,
    input  logic             incr_i,
    output logic [WIDTH:0]   sum_o,
    output logic             incr_seen_o
);

    localparam int NSEG = (WIDTH + SEG_W - 1) / SEG_W;

    // Purpose: carry out of the top position for the 2.0 case.
    assign sum_o[WIDTH] = incr_i & (&val_i);
    assign incr_seen_o  = incr_i;

    for (genvar k = 0; k < NSEG; k++) begin : g_seg
        localparam int LO = k * SEG_W;
        localparam int HI = (k == NSEG - 1) ? (WIDTH - 1) : (LO + SEG_W - 1);
        localparam int SW = HI - LO + 1;
        logic seg_cin;

        // Purpose: segment carry-in from the increment and lower all-ones bits.
        if (k == 0) begin : g_first
            assign seg_cin = incr_i;
        end else begin : g_upper
            assign seg_cin = incr_i & (&val_i[LO-1:0]);
        end

        // Purpose: segment sum with its carry-in.
        assign sum_o[HI:LO] = val_i[HI:LO] + SW'(seg_cin);
    end

endmodule

// File: rtl/mant_round.sv
// Module: mant_round (top)
// Combinational rounding stage. Strips the guard and round bits (the two
// LSBs of mant_i), decides on an increment from the mode, sign and sticky
// bit, and applies the increment with full carry. A carry past the leading
// bit appears in the top bit of mant_o and is not renormalised here.
// Assumes MANT_W >= 4.
module mant_round #(
    parameter int MANT_W = 56,
    parameter int SEG_W  = 8
) (
    input  logic [MANT_W-1:0] mant_i,
    input  logic              sticky_i,
    input  logic              sign_i,
    input  logic [1:0]        mode_i,
    output logic [MANT_W-2:0] mant_o,
    output logic              round_up_o,
    output logic              inexact_o,
    output logic              frac_rounded_o
);

    localparam int TRUNC_W = MANT_W - 2;

    logic [TRUNC_W-1:0] trunc;
    logic               incr;

    // Purpose: drop guard and round with a fixed 2-bit shift.
    assign trunc = mant_i[MANT_W-1:2];

    mant_round_decide u_decide (
        .guard_i   (mant_i[1]),
        .round_i   (mant_i[0]),
        .sticky_i  (sticky_i),
        .lsb_i     (mant_i[2]),
        .sign_i    (sign_i),
        .mode_i    (mode_i),
        .inexact_o (inexact_o),
        .incr_o    (incr)
    );

    mant_round_incr #(
        .WIDTH (TRUNC_W),
        .SEG_W (SEG_W)
    ) u_incr (
        .val_i       (trunc),
        .incr_i      (incr),
        .sum_o       (mant_o),
        .incr_seen_o (frac_rounded_o)
    );

    // Purpose: report that an increment was applied.
    assign round_up_o = incr;

endmodule

// File: rtl/mant_round_chk.sv
// Module: mant_round_chk
// Assertion checker bound to mant_round. Relates the ports of the
// combinational stage; only evaluated when all inputs are known.
module mant_round_chk #(
    parameter int MANT_W = 56
) (
    input logic [MANT_W-1:0] mant_i,
    input logic              sticky_i,
    input logic              sign_i,
    input logic [1:0]        mode_i,
    input logic [MANT_W-2:0] mant_o,
    input logic              round_up_o,
    input logic              inexact_o,
    input logic              frac_rounded_o
);

    logic [MANT_W-2:0] base;
    logic              lost;

    assign base = {1'b0, mant_i[MANT_W-1:2]};
    assign lost = mant_i[1] | mant_i[0] | sticky_i;

    always_comb begin
        if (!$isunknown({mant_i, sticky_i, sign_i, mode_i})) begin
            assert_exact_R2: assert (lost || (!round_up_o && !inexact_o && !frac_rounded_o))
                else $error("exact input raised a flag");
            assert_inexact_R3: assert (inexact_o == lost)
                else $error("inexact flag mismatch");
            assert_ties_R4: assert (mode_i != 2'b00 || mant_i[1] || !round_up_o)
                else $error("nearest rounded up without guard");
            assert_no_incr_rz_R5: assert (mode_i != 2'b01 || !round_up_o)
                else $error("toward-zero incremented");
            assert_pos_dir_R6: assert (mode_i != 2'b10 || !sign_i || !round_up_o)
                else $error("toward +inf incremented a negative");
            assert_neg_dir_R7: assert (mode_i != 2'b11 || sign_i || !round_up_o)
                else $error("toward -inf incremented a positive");
            assert_incr_value_R8: assert (mant_o == base + (MANT_W-1)'(round_up_o))
                else $error("rounded value mismatch");
            assert_flag_pair_R8: assert (frac_rounded_o == round_up_o)
                else $error("fraction-rounded and round-up disagree");
            assert_pass_R1: assert (round_up_o || mant_o == base)
                else $error("truncated value not passed through");
        end
    end

endmodule

bind mant_round mant_round_chk #(.MANT_W(MANT_W)) u_chk (
    .mant_i         (mant_i),
    .sticky_i       (sticky_i),
    .sign_i         (sign_i),
    .mode_i         (mode_i),
    .mant_o         (mant_o),
    .round_up_o     (round_up_o),
    .inexact_o      (inexact_o),
    .frac_rounded_o (frac_rounded_o)
);

// File: tb/mant_round_test.sv
// Directed bench for mant_round: one task per scenario, each checking itself.
module mant_round_test;

    localparam int W  = 56;
    localparam int TW = W - 2;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [W-1:0]  mant   = '0;
    logic          sticky = 1'b0;
    logic          sign   = 1'b0;
    logic [1:0]    mode   = 2'b00;
    logic [TW:0]   mo;
    logic          ru, ix, fr;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    mant_round #(.MANT_W(W)) uut (
        .mant_i         (mant),
        .sticky_i       (sticky),
        .sign_i         (sign),
        .mode_i         (mode),
        .mant_o         (mo),
        .round_up_o     (ru),
        .inexact_o      (ix),
        .frac_rounded_o (fr)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // Apply one input set on the falling edge, sample 1 ns later.
    task automatic run(input string req, input logic [W-1:0] m, input logic s,
                       input logic sg, input logic [1:0] md);
        logic [TW-1:0] tr;
        logic          inx, inc;
        logic [TW:0]   expm;
        @(negedge clk);
        mant = m; sticky = s; sign = sg; mode = md;
        #1;
        tr  = m[W-1:2];
        inx = m[1] | m[0] | s;
        case (md)
            2'b00:   inc = m[1] & (m[0] | s | tr[0]);
            2'b01:   inc = 1'b0;
            2'b10:   inc = inx & ~sg;
            default: inc = inx & sg;
        endcase
        expm = {1'b0, tr} + (TW+1)'(inc);
        chk(req, "mant_o", 64'(mo), 64'(expm));
        chk(req, "round_up_o", 64'(ru), 64'(inc));
        chk(req, "inexact_o", 64'(ix), 64'(inx));
        chk(req, "frac_rounded_o", 64'(fr), 64'(inc));
    endtask

    task automatic t_reset_R2();
        chk("R2", "reset mant_o", 64'(mo), 64'd0);
        chk("R2", "reset flags", 64'({ru, ix, fr}), 64'd0);
    endtask

    task automatic t_exact_R2();
        for (int md = 0; md < 4; md++) begin
            run("R2", 56'h0ABC_DEF0_1234_5C, 1'b0, md[0], md[1:0]);
            chk("R2", "no round_up", 64'(ru), 64'd0);
        end
    endtask

    task automatic t_nearest_R4();
        run("R4", 56'h0000_0000_0000_08 | 56'h2, 1'b0, 1'b0, 2'b00); // tie, even
        chk("R4", "tie even kept", 64'(ru), 64'd0);
        run("R4", 56'h0000_0000_0000_04 | 56'h2, 1'b0, 1'b0, 2'b00); // tie, odd
        chk("R4", "tie odd bumped", 64'(mo), 64'h2);
        run("R4", 56'h8000_0000_0000_03, 1'b0, 1'b1, 2'b00);          // above half
        run("R4", 56'h8000_0000_0000_02, 1'b1, 1'b0, 2'b00);          // half + sticky
        run("R4", 56'h8000_0000_0000_01, 1'b1, 1'b0, 2'b00);          // below half
        chk("R4", "below half kept", 64'(ru), 64'd0);
    endtask

    task automatic t_zero_R5();
        run("R5", 56'hFFFF_FFFF_FFFF_FF, 1'b1, 1'b0, 2'b01);
        chk("R5", "no increment", 64'(ru), 64'd0);
        run("R5", 56'h1234_5678_9ABC_DE, 1'b1, 1'b1, 2'b01);
    endtask

    task automatic t_pos_R6();
        run("R6", 56'h4000_0000_0000_00, 1'b1, 1'b0, 2'b10);
        chk("R6", "positive bumped", 64'(ru), 64'd1);
        run("R6", 56'h4000_0000_0000_01, 1'b0, 1'b1, 2'b10);
        chk("R6", "negative kept", 64'(ru), 64'd0);
    endtask

    task automatic t_neg_R7();
        run("R7", 56'h4000_0000_0000_02, 1'b0, 1'b1, 2'b11);
        chk("R7", "negative bumped", 64'(ru), 64'd1);
        run("R7", 56'h4000_0000_0000_00, 1'b1, 1'b0, 2'b11);
        chk("R7", "positive kept", 64'(ru), 64'd0);
    endtask

    task automatic t_carry_R8();
        run("R8", 56'h0000_0000_03FF_FE, 1'b0, 1'b0, 2'b00); // ripple across segments
        chk("R8", "ripple", 64'(mo), 64'h0001_0000);
    endtask

    task automatic t_carry_out_R9();
        run("R9", {W{1'b1}}, 1'b0, 1'b0, 2'b00);
        chk("R9", "2.0 result", 64'(mo), 64'(1) << TW);
        run("R9", {{TW{1'b1}}, 2'b00}, 1'b1, 1'b0, 2'b10);
        chk("R9", "carry bit", 64'(mo[TW]), 64'd1);
    endtask

    task automatic t_sweep_R1();
        for (int i = 0; i < 400; i++) begin
            logic [63:0] rv;
            rv = {$urandom(), $urandom()};
            run("R1", rv[W-1:0], rv[60], rv[61], rv[63:62]);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        t_reset_R2();
        rst_n = 1'b1;
        t_exact_R2();
        t_nearest_R4();
        t_zero_R5();
        t_pos_R6();
        t_neg_R7();
        t_carry_R8();
        t_carry_out_R9();
        t_sweep_R1();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (all): actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule